// File: doc/BRIEF.md
# DQS receive-enable gate timer

This block decides, for every byte lane of a DDR read data bus, when the DQS receiver may start listening. The goal is to open that window in the middle of the read preamble. Opening it too early lets noise through, and opening it too late loses real strobe edges. Each read launched by the core produces, per lane, a one-cycle coarse enable pulse. That pulse comes with a quarter-clock phase select and a sub-quarter tap code, which together steer the physical delay line that sits outside this block.

Each lane owns an 8-bit delay code, and both ranks share it. The code splits into three fields:

- Bits [7:5] add whole core cycles on top of the read latency (CAS latency plus additive latency).
- Bits [4:3] pick one of four quarter-cycle phases.
- Bits [2:0] go through a remap table before reaching the tap output. The table is indexed by a 3-bit delay-line calibration value. When the calibration is coarse, neighbouring codes land on the same tap, so some code steps add no delay.

Several reads may be pending at once. Each one carries the code and calibration it saw at launch.

Top module: `dqs_gate_timer`

## Requirements
- R1: The read-launch strobe is sampled high in cycle n. Each lane then pulses `gate_pulse_o` high for one cycle in cycle n+L, where L = CL + AL + code[7:5].
- R2: During a lane's pulse, its quarter output equals code[4:3] of the read that produced the pulse.
- R3: During a lane's pulse, its tap output equals the remap of code[2:0] under calibration C. The table below lists the tap for code[2:0] = 0 to 7, for each value of C:

  | C | Taps for code[2:0] = 0..7 |
  |---|---|
  | 7 | 0,1,2,3,4,5,6,7 |
  | 6 | 0,1,2,3,4,4,5,6 |
  | 5 | 0,1,2,2,3,4,5,5 |
  | 4 | 0,1,1,2,3,3,4,4 |
  | 3 | 0,0,1,1,2,2,3,3 |
  | 2 | 0,0,0,1,1,1,2,2 |
  | 1 | 0,0,0,0,1,1,1,1 |
  | 0 | all 0 |

- R4: Code 0x00 gives L = CL+AL with quarter 0 and tap 0. Code 0xFF gives L = CL+AL+7 with quarter 3 and the tap for code[2:0] = 7.
- R5: Code, calibration, CL and AL are captured with the strobe. Changing them later does not alter a read already pending.
- R6: Strobes in consecutive cycles each produce their own pulse. Up to DEPTH (default 4) reads can be pending at once.
- R7: If two pending reads complete in the same cycle on a lane, one pulse is issued, carrying the fields of the later-launched read.
- R8: A read is discarded, and never pulses, if DEPTH further strobes arrive before the cycle in which it would pulse.
- R9: Outside a pulse, each lane's quarter and tap outputs hold the values of that lane's most recent pulse. After reset they hold zero.
- R10: Synchronous active-high reset drops all pending reads and drives every output to zero.
- R11: If CL + AL + code[7:5] is 0, the read pulses in cycle n+1.
- R12: Lanes are independent: each lane's pulse timing and fields depend only on its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_launch_i | input | 1 | High for one cycle for each read command launched |
| lane_code_i | input | LANES*8 | Delay code per lane; lane l occupies bits [8l+7:8l] |
| dl_cal_i | input | 3 | Delay-line calibration value used by the tap remap |
| cas_lat_i | input | 4 | CAS latency in core cycles |
| add_lat_i | input | 3 | Additive latency in core cycles |
| gate_pulse_o | output | LANES | Coarse enable pulse per lane |
| gate_qtr_o | output | LANES*2 | Quarter-phase select per lane |
| gate_tap_o | output | LANES*3 | Sub-quarter tap code per lane |

## Verification
The bench sweeps all 64 combinations of calibration and low code bits. A wrong remap row would put a shifted or saturated tap on the pulse. It launches two reads whose completions coincide; a design that picks the older read would show its quarter and tap instead of the newer ones. It also tests the following cases:
- It changes the code and calibration right after a strobe, which exposes a design that reads live inputs at completion.
- It sends DEPTH+1 strobes in a row against a long latency. A design that keeps or loses the wrong entry would show an extra or a missing pulse.
- It uses a zero latency, which would wrap a countdown that is not clamped.

// File: rtl/dqs_gate_pkg.sv
package dqs_gate_pkg;

    localparam int CODE_W = 8;
    localparam int CL_W   = 4;
    localparam int AL_W   = 3;
    localparam int CAL_W  = 3;
    localparam int CYC_W  = 3;
    localparam int QTR_W  = 2;
    localparam int TAP_W  = 3;
    localparam int ROW_W  = TAP_W << TAP_W;
    localparam int CNT_W  = $clog2((1 << CL_W) + (1 << AL_W) + (1 << CYC_W));

    // Field split of a lane delay code; packed order follows bit order.
    typedef struct packed {
        logic [CYC_W-1:0] cyc;
        logic [QTR_W-1:0] qtr;
        logic [TAP_W-1:0] sub;
    } delay_code_t;

    // One pending read for one lane.
    typedef struct packed {
        logic             live;
        logic [CNT_W-1:0] cnt;
        logic [QTR_W-1:0] qtr;
        logic [TAP_W-1:0] tap;
    } gate_slot_t;

    // Tap row per calibration value, entry for sub-code k at bits [3k+2:3k].
    function automatic logic [ROW_W-1:0] tap_row(input logic [CAL_W-1:0] cal);
        case (cal)
            3'd7:    tap_row = {3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
            3'd6:    tap_row = {3'd6, 3'd5, 3'd4, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0};
            3'd5:    tap_row = {3'd5, 3'd5, 3'd4, 3'd3, 3'd2, 3'd2, 3'd1, 3'd0};
            3'd4:    tap_row = {3'd4, 3'd4, 3'd3, 3'd3, 3'd2, 3'd1, 3'd1, 3'd0};
            3'd3:    tap_row = {3'd3, 3'd3, 3'd2, 3'd2, 3'd1, 3'd1, 3'd0, 3'd0};
            3'd2:    tap_row = {3'd2, 3'd2, 3'd1, 3'd1, 3'd1, 3'd0, 3'd0, 3'd0};
            3'd1:    tap_row = {3'd1, 3'd1, 3'd1, 3'd1, 3'd0, 3'd0, 3'd0, 3'd0};
            default: tap_row = '0;
        endcase
    endfunction

    function automatic logic [TAP_W-1:0] remap_tap(input logic [CAL_W-1:0] cal,
                                                   input logic [TAP_W-1:0] sub);
        logic [ROW_W-1:0] row;
        row = tap_row(cal);
        remap_tap = row[int'(sub)*TAP_W +: TAP_W];
    endfunction

    // Countdown start value: latency minus one, with zero latency clamped to one.
    function automatic logic [CNT_W-1:0] start_count(input logic [CL_W-1:0]  cl,
                                                     input logic [AL_W-1:0]  al,
                                                     input logic [CYC_W-1:0] cyc);
        logic [CNT_W-1:0] sum;
        sum = CNT_W'(cl) + CNT_W'(al) + CNT_W'(cyc);
        start_count = (sum == '0) ? '0 : sum - CNT_W'(1);
    endfunction

endpackage

// File: rtl/dqs_tap_remap.sv
module dqs_tap_remap
    import dqs_gate_pkg::*;
(
    input  logic [CAL_W-1:0] cal_i,
    input  logic [TAP_W-1:0] sub_i,
    output logic [TAP_W-1:0] tap_o
);

    assign tap_o = remap_tap(cal_i, sub_i);

    // R3: a remapped tap never exceeds the calibration value nor the raw sub-code.
    always_comb begin
        if (!$isunknown({cal_i, sub_i})) begin
            assert_tap_bound_R3: assert (tap_o <= cal_i && tap_o <= sub_i);
        end
    end

endmodule

// File: rtl/dqs_lane_tracker.sv
module dqs_lane_tracker
    import dqs_gate_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch_i,
    input  logic [CYC_W-1:0] cyc_i,
    input  logic [QTR_W-1:0] qtr_i,
    input  logic [TAP_W-1:0] tap_i,
    input  logic [CL_W-1:0]  cl_i,
    input  logic [AL_W-1:0]  al_i,
    output logic             fire_o,
    output logic [QTR_W-1:0] qtr_o,
    output logic [TAP_W-1:0] tap_o
);

    gate_slot_t slot_q [DEPTH];
    gate_slot_t aged   [DEPTH];
    gate_slot_t slot_d [DEPTH];
    gate_slot_t fresh;
    gate_slot_t hit_slot;
    logic       hit;
    logic [QTR_W-1:0] held_qtr_q;
    logic [TAP_W-1:0] held_tap_q;

    always_comb begin
        fresh.live = 1'b1;
        fresh.cnt  = start_count(cl_i, al_i, cyc_i);
        fresh.qtr  = qtr_i;
        fresh.tap  = tap_i;
    end

    // Age every slot: a slot at zero completes this cycle and retires.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            aged[i] = slot_q[i];
            if (slot_q[i].live) begin
                if (slot_q[i].cnt == '0) aged[i].live = 1'b0;
                else                     aged[i].cnt  = slot_q[i].cnt - CNT_W'(1);
            end
        end
    end

    // Shift pipeline: a launch enters at slot 0; the last slot falls off.
    always_comb begin
        slot_d[0] = launch_i ? fresh : aged[0];
        for (int i = 1; i < DEPTH; i++) begin
            slot_d[i] = launch_i ? aged[i-1] : aged[i];
        end
    end

    // Completion select: lowest index (newest read) wins on coincidence.
    always_comb begin
        hit      = 1'b0;
        hit_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (slot_q[i].live && slot_q[i].cnt == '0) begin
                hit      = 1'b1;
                hit_slot = slot_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
            held_qtr_q <= '0;
            held_tap_q <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
            if (hit) begin
                held_qtr_q <= hit_slot.qtr;
                held_tap_q <= hit_slot.tap;
            end
        end
    end

    assign fire_o = hit;
    assign qtr_o  = hit ? hit_slot.qtr : held_qtr_q;
    assign tap_o  = hit ? hit_slot.tap : held_tap_q;

    assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (!fire_o && qtr_o == '0 && tap_o == '0));

    assert_hold_fields_R9: assert property (@(posedge clk) disable iff (rst)
        !fire_o |-> (qtr_o == $past(qtr_o) && tap_o == $past(tap_o)));

    assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
        launch_i |=> (slot_q[0].live && slot_q[0].qtr == $past(qtr_i)
                      && slot_q[0].tap == $past(tap_i)));

    assert_one_cycle_min_R11: assert property (@(posedge clk) disable iff (rst)
        (launch_i && cl_i == '0 && al_i == '0 && cyc_i == '0) |=> fire_o);

endmodule

// File: rtl/dqs_gate_timer.sv
module dqs_gate_timer
    import dqs_gate_pkg::*;
#(
    parameter int LANES = 2,
    parameter int DEPTH = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   rd_launch_i,
    input  logic [LANES*CODE_W-1:0] lane_code_i,
    input  logic [CAL_W-1:0]       dl_cal_i,
    input  logic [CL_W-1:0]        cas_lat_i,
    input  logic [AL_W-1:0]        add_lat_i,
    output logic [LANES-1:0]       gate_pulse_o,
    output logic [LANES*QTR_W-1:0] gate_qtr_o,
    output logic [LANES*TAP_W-1:0] gate_tap_o
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        delay_code_t       code;
        logic [TAP_W-1:0]  tap_mapped;

        assign code = delay_code_t'(lane_code_i[l*CODE_W +: CODE_W]);

        dqs_tap_remap i_remap (
            .cal_i (dl_cal_i),
            .sub_i (code.sub),
            .tap_o (tap_mapped)
        );

        dqs_lane_tracker #(.DEPTH(DEPTH)) i_track (
            .clk      (clk),
            .rst      (rst),
            .launch_i (rd_launch_i),
            .cyc_i    (code.cyc),
            .qtr_i    (code.qtr),
            .tap_i    (tap_mapped),
            .cl_i     (cas_lat_i),
            .al_i     (add_lat_i),
            .fire_o   (gate_pulse_o[l]),
            .qtr_o    (gate_qtr_o[l*QTR_W +: QTR_W]),
            .tap_o    (gate_tap_o[l*TAP_W +: TAP_W])
        );
    end

endmodule

// File: tb/test_dqs_gate_timer.sv
module test_dqs_gate_timer;

    localparam int LANES = 2;
    localparam int DEPTH = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 rd_launch = 1'b0;
    logic [LANES*8-1:0]   lane_code = '0;
    logic [2:0]           dl_cal = 3'd7;
    logic [3:0]           cas_lat = 4'd0;
    logic [2:0]           add_lat = 3'd0;
    logic [LANES-1:0]     gate_pulse;
    logic [LANES*2-1:0]   gate_qtr;
    logic [LANES*3-1:0]   gate_tap;

    always #10 clk = ~clk;

    dqs_gate_timer #(.LANES(LANES), .DEPTH(DEPTH)) i_dqs_gate_timer (
        .clk          (clk),
        .rst          (rst),
        .rd_launch_i  (rd_launch),
        .lane_code_i  (lane_code),
        .dl_cal_i     (dl_cal),
        .cas_lat_i    (cas_lat),
        .add_lat_i    (add_lat),
        .gate_pulse_o (gate_pulse),
        .gate_qtr_o   (gate_qtr),
        .gate_tap_o   (gate_tap)
    );

    typedef struct {
        int lane;
        int fire;
        int id;
        int q;
        int t;
    } exp_t;

    exp_t  sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    int    launch_id = 0;
    int    held_q[LANES];
    int    held_t[LANES];
    bit    done = 0;
    string phase = "R1";

    // Tap by [calibration][sub-code], sub-code ascending.
    int tbl[8][8] = '{
        '{0,0,0,0,0,0,0,0},
        '{0,0,0,0,1,1,1,1},
        '{0,0,0,1,1,1,2,2},
        '{0,0,1,1,2,2,3,3},
        '{0,1,1,2,3,3,4,4},
        '{0,1,2,2,3,4,5,5},
        '{0,1,2,3,4,4,5,6},
        '{0,1,2,3,4,5,6,7}
    };

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int lat_of(input int cl, input int al, input int c);
        int l;
        l = cl + al + c;
        return (l == 0) ? 1 : l;
    endfunction

    // Driver: strobe one read and queue the expected per-lane results.
    task automatic launch(input logic [7:0] c0, input logic [7:0] c1,
                          input int cal, input int cl, input int al);
        logic [7:0] cv;
        int n;
        @(negedge clk);
        rd_launch = 1'b1;
        lane_code = {c1, c0};
        dl_cal    = 3'(cal);
        cas_lat   = 4'(cl);
        add_lat   = 3'(al);
        n = cyc;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].id <= launch_id - DEPTH && sb[i].fire > n) sb.delete(i);
        end
        for (int l = 0; l < LANES; l++) begin
            exp_t e;
            cv     = (l == 0) ? c0 : c1;
            e.lane = l;
            e.fire = n + lat_of(cl, al, int'(cv[7:5]));
            e.id   = launch_id;
            e.q    = int'(cv[4:3]);
            e.t    = tbl[cal][cv[2:0]];
            sb.push_back(e);
        end
        launch_id++;
    endtask

    task automatic gap(input int n);
        repeat (n) begin
            @(negedge clk);
            rd_launch = 1'b0;
        end
    endtask

    // Idle cycles with scrambled code, calibration and latency inputs.
    task automatic gap_scramble(input int n);
        repeat (n) begin
            @(negedge clk);
            rd_launch = 1'b0;
            lane_code = ~lane_code;
            dl_cal    = dl_cal ^ 3'd5;
            cas_lat   = cas_lat + 4'd3;
            add_lat   = add_lat + 3'd1;
        end
    endtask

    // Monitor: compare each lane every cycle against the scoreboard.
    always @(negedge clk) begin
        if (!rst && !done) begin
            for (int l = 0; l < LANES; l++) begin
                int  best;
                int  bq;
                int  bt;
                int  aq;
                int  at;
                best = -1;
                bq   = 0;
                bt   = 0;
                for (int i = sb.size() - 1; i >= 0; i--) begin
                    if (sb[i].lane == l && sb[i].fire <= cyc) begin
                        if (sb[i].fire == cyc && sb[i].id > best) begin
                            best = sb[i].id;
                            bq   = sb[i].q;
                            bt   = sb[i].t;
                        end
                        sb.delete(i);
                    end
                end
                aq = int'(gate_qtr[l*2 +: 2]);
                at = int'(gate_tap[l*3 +: 3]);
                if (best >= 0) begin
                    check(gate_pulse[l] == 1'b1, phase, $sformatf("lane %0d pulse", l),
                          int'(gate_pulse[l]), 1);
                    check(aq == bq, phase, $sformatf("lane %0d quarter", l), aq, bq);
                    check(at == bt, phase, $sformatf("lane %0d tap", l), at, bt);
                    held_q[l] = bq;
                    held_t[l] = bt;
                end else begin
                    check(gate_pulse[l] == 1'b0, phase, $sformatf("lane %0d no pulse", l),
                          int'(gate_pulse[l]), 0);
                    check(aq == held_q[l] && at == held_t[l], "R9",
                          $sformatf("lane %0d held q*8+t", l), aq*8 + at,
                          held_q[l]*8 + held_t[l]);
                end
            end
        end
    end

    task automatic reset_check(input int cycles);
        @(negedge clk);
        rst = 1'b1;
        rd_launch = 1'b0;
        sb.delete();
        for (int l = 0; l < LANES; l++) begin
            held_q[l] = 0;
            held_t[l] = 0;
        end
        repeat (cycles) @(negedge clk);
        check(gate_pulse == '0, "R10", "pulses in reset", int'(gate_pulse), 0);
        check(gate_qtr == '0 && gate_tap == '0, "R10", "fields in reset",
              int'({gate_qtr, gate_tap}), 0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int l = 0; l < LANES; l++) begin
            held_q[l] = 0;
            held_t[l] = 0;
        end
        reset_check(3);

        // R4 R12: extremes, different code per lane.
        phase = "R4";
        launch(8'h00, 8'hFF, 7, 5, 2);
        gap(16);
        launch(8'hFF, 8'h00, 7, 5, 2);
        gap(16);

        // R3 R12: full calibration / sub-code sweep, back to back.
        phase = "R3";
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 8; k++) begin
                launch(8'({3'd0, 2'(k), 3'(k)}), 8'({3'd1, 2'(3 - (k % 4)), 3'(7 - k)}),
                       c, 2, 1);
            end
        end
        gap(10);

        // R5: inputs scrambled right after the strobe.
        phase = "R5";
        launch(8'h6B, 8'hB6, 4, 3, 1);
        gap_scramble(14);
        gap(2);

        // R6 R2: four consecutive reads with different codes.
        phase = "R6";
        launch(8'h21, 8'hE7, 7, 3, 0);
        launch(8'h4A, 8'h9C, 6, 3, 0);
        launch(8'h73, 8'h15, 5, 3, 0);
        launch(8'h0E, 8'h38, 3, 3, 0);
        gap(16);

        // R7: the newer read completes in the same cycle as the older.
        phase = "R7";
        launch(8'h6A, 8'h6A, 7, 4, 0);
        launch(8'h55, 8'h55, 7, 4, 0);
        gap(12);

        // R8: DEPTH+1 strobes against a long latency drop the first read.
        phase = "R8";
        launch(8'hE3, 8'hFF, 7, 10, 5);
        launch(8'h08, 8'h11, 7, 10, 5);
        launch(8'h12, 8'h2A, 7, 10, 5);
        launch(8'h1C, 8'h33, 7, 10, 5);
        launch(8'h05, 8'h0D, 7, 10, 5);
        gap(30);

        // R11: zero latency clamps to one cycle.
        phase = "R11";
        launch(8'h07, 8'h1F, 7, 0, 0);
        gap(4);

        // R10: reset while reads are pending, then none of them pulse.
        phase = "R10";
        launch(8'hFF, 8'hEE, 7, 8, 4);
        gap(3);
        reset_check(2);
        gap(25);

        // R1: plain timing after reset.
        phase = "R1";
        launch(8'h40, 8'hA0, 7, 6, 3);
        gap(20);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule